// File: doc/BRIEF.md
# Dual-Lane Registered Bus Transceiver

This block joins two bidirectional buses, A and B, each 16 bits wide, and splits them into two 8-bit lanes that share nothing. Each lane has its own controls: a direction bit, an active-low enable, and two source selects. Each lane drives one of its buses at a time. The value driven is either the live value on the opposite bus or a copy held in one of the lane's two capture registers. Tri-state pads sit outside the block. Each bus is modelled as an input vector, an output vector and a per-bit drive enable.

Each lane has two capture registers. One holds A-bus data and the other holds B-bus data, and each is loaded by its own capture strobe. The whole block runs on one system clock. A register loads at a clock edge where its strobe is sampled high after being sampled low at the edge before. The registers sample the bus input pins, not the block's outputs. Data can therefore be stored while the lane drives nothing, and the two registers can load at the same edge or at separate edges. Reset is synchronous and active high. It clears both registers and the strobe history.

Top module: `bxcvr_top`

## Requirements
- R1: Lane 0 owns bits 7:0 and lane 1 owns bits 15:8 of every bus vector. A lane's controls and strobes never change another lane's bits.
- R2: While a lane's `oe_n` is 1, that lane's bits of `a_oe`, `b_oe`, `a_out` and `b_out` are all 0.
- R3: While `oe_n` is 0, `dir` = 1 sets the lane's `b_oe` bits to all ones and its `a_oe` bits to 0. `dir` = 0 does the reverse. `a_oe` and `b_oe` are never both set in a lane.
- R4: When a lane drives B, `sel_ab` = 0 puts that lane's current `a_in` bits on `b_out` in the same cycle. `sel_ab` = 1 puts the lane's A register on `b_out`.
- R5: When a lane drives A, `sel_ba` = 0 puts that lane's current `b_in` bits on `a_out` in the same cycle. `sel_ba` = 1 puts the lane's B register on `a_out`.
- R6: A lane's A register loads that lane's `a_in` bits at a clock edge where `cap_a` is 1 and `cap_a` was 0 at the previous edge. It holds its value at all other edges. The B register does the same with `cap_b` and `b_in`.
- R7: Capture does not depend on `oe_n`, `dir` or the selects. A value stored while the lane is isolated appears later on the stored path.
- R8: The A and B registers of a lane can both load at the same edge, each from its own bus.
- R9: Reset clears both registers of every lane to zero. A strobe that is high at the first edge after reset counts as a rising edge.
- R10: While the stored path is driven, the output keeps the old register value up to the capture edge and shows the new value from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 2 | Per-lane active-low output enable |
| dir | input | 2 | Per-lane direction: 1 drives B, 0 drives A |
| sel_ab | input | 2 | Per-lane B-side source: 0 live A, 1 stored A |
| sel_ba | input | 2 | Per-lane A-side source: 0 live B, 1 stored B |
| cap_a | input | 2 | Per-lane A-register capture strobe |
| cap_b | input | 2 | Per-lane B-register capture strobe |
| a_in | input | 16 | Value seen on the A bus pins |
| a_out | output | 16 | Value to drive on the A bus |
| a_oe | output | 16 | Per-bit drive enable for the A bus |
| b_in | input | 16 | Value seen on the B bus pins |
| b_out | output | 16 | Value to drive on the B bus |
| b_oe | output | 16 | Per-bit drive enable for the B bus |

## Verification
The case that needs care is a capture edge that falls while the same register is being driven onto the opposite bus. In that cycle the old stored value must stay on the output up to the edge, and the new value must appear from the edge on. The bench sets up this collision directly: it holds the stored path selected, presents fresh bus data and raises the strobe. It checks the output once before the edge and once after. A long random run then keeps the strobes and selects of both lanes changing against a behavioural model, checked every clock, so collisions and same-edge dual loads happen often.

// File: rtl/bxcvr_pkg.sv
package bxcvr_pkg;

    parameter int LANE_W = 8;
    parameter int LANES  = 2;
    localparam int BUS_W = LANE_W * LANES;

    typedef logic [LANE_W-1:0] lane_data_t;

    typedef struct packed {
        logic oe_n;
        logic dir;
        logic sel_ab;
        logic sel_ba;
    } lane_ctrl_t;

    typedef enum logic [1:0] {
        PATH_OFF = 2'd0,
        PATH_A2B = 2'd1,
        PATH_B2A = 2'd2
    } path_e;

    function automatic path_e decode_path(input lane_ctrl_t c);
        if (c.oe_n)     return PATH_OFF;
        else if (c.dir) return PATH_A2B;
        else            return PATH_B2A;
    endfunction

    function automatic lane_data_t pick_src(input logic use_held,
                                            input lane_data_t live,
                                            input lane_data_t held);
        return use_held ? held : live;
    endfunction

endpackage

// File: rtl/bxcvr_rise_det.sv
module bxcvr_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= strobe;
    end

    assign rise = strobe & ~seen_q;

    AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R6

endmodule

// File: rtl/bxcvr_hold_reg.sv
module bxcvr_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q)); // R6
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(d)); // R6
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> q == '0); // R9

endmodule

// File: rtl/bxcvr_lane.sv
module bxcvr_lane
    import bxcvr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lane_ctrl_t ctrl,
    input  logic       cap_a,
    input  logic       cap_b,
    input  lane_data_t a_in,
    input  lane_data_t b_in,
    output lane_data_t a_out,
    output lane_data_t a_oe,
    output lane_data_t b_out,
    output lane_data_t b_oe
);
    logic       load_a, load_b;
    lane_data_t held_a, held_b;
    path_e      path;

    bxcvr_rise_det u_rise_a (.clk(clk), .rst(rst), .strobe(cap_a), .rise(load_a));
    bxcvr_rise_det u_rise_b (.clk(clk), .rst(rst), .strobe(cap_b), .rise(load_b));

    bxcvr_hold_reg #(.W(LANE_W)) u_reg_a (
        .clk(clk), .rst(rst), .load(load_a), .d(a_in), .q(held_a));
    bxcvr_hold_reg #(.W(LANE_W)) u_reg_b (
        .clk(clk), .rst(rst), .load(load_b), .d(b_in), .q(held_b));

    always_comb begin
        path  = decode_path(ctrl);
        a_out = '0;
        b_out = '0;
        a_oe  = '0;
        b_oe  = '0;
        unique case (path)
            PATH_A2B: begin
                b_oe  = '1;
                b_out = pick_src(ctrl.sel_ab, a_in, held_a);
            end
            PATH_B2A: begin
                a_oe  = '1;
                a_out = pick_src(ctrl.sel_ba, b_in, held_b);
            end
            default: ;
        endcase
    end

    AST_LANE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        ctrl.oe_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0)); // R2
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        !((|a_oe) && (|b_oe))); // R3
    AST_STORED_A_PATH: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.oe_n && ctrl.dir && ctrl.sel_ab) |-> b_out == held_a); // R4
    AST_STORED_B_PATH: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.oe_n && !ctrl.dir && ctrl.sel_ba) |-> a_out == held_b); // R5

endmodule

// File: rtl/bxcvr_top.sv
module bxcvr_top
    import bxcvr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] oe_n,
    input  logic [LANES-1:0] dir,
    input  logic [LANES-1:0] sel_ab,
    input  logic [LANES-1:0] sel_ba,
    input  logic [LANES-1:0] cap_a,
    input  logic [LANES-1:0] cap_b,
    input  logic [BUS_W-1:0] a_in,
    output logic [BUS_W-1:0] a_out,
    output logic [BUS_W-1:0] a_oe,
    input  logic [BUS_W-1:0] b_in,
    output logic [BUS_W-1:0] b_out,
    output logic [BUS_W-1:0] b_oe
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_ctrl_t ctrl;
        assign ctrl = '{oe_n: oe_n[g], dir: dir[g], sel_ab: sel_ab[g], sel_ba: sel_ba[g]};

        bxcvr_lane u_lane (
            .clk   (clk),
            .rst   (rst),
            .ctrl  (ctrl),
            .cap_a (cap_a[g]),
            .cap_b (cap_b[g]),
            .a_in  (a_in [g*LANE_W +: LANE_W]),
            .b_in  (b_in [g*LANE_W +: LANE_W]),
            .a_out (a_out[g*LANE_W +: LANE_W]),
            .a_oe  (a_oe [g*LANE_W +: LANE_W]),
            .b_out (b_out[g*LANE_W +: LANE_W]),
            .b_oe  (b_oe [g*LANE_W +: LANE_W])
        );
    end

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
        (a_oe & b_oe) == '0); // R3

endmodule

// File: tb/bxcvr_top_tb_top.sv
`timescale 1ns/1ps
module bxcvr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  oe_n, dir, sel_ab, sel_ba, cap_a, cap_b;
    logic [15:0] a_in, b_in;
    logic [15:0] a_out, a_oe, b_out, b_oe;

    int total = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0] ma [2];
    logic [7:0] mb [2];
    logic       pa [2];
    logic       pb [2];

    always #2 clk = ~clk;

    bxcvr_top dut_i (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab),
        .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b), .a_in(a_in),
        .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // Behavioural reference: capture on strobe rising between clock edges.
    always @(posedge clk) begin
        for (int l = 0; l < 2; l++) begin
            if (rst) begin
                ma[l] = 8'h00; mb[l] = 8'h00; pa[l] = 1'b0; pb[l] = 1'b0;
            end else begin
                if (cap_a[l] && !pa[l]) ma[l] = a_in[l*8 +: 8];
                if (cap_b[l] && !pb[l]) mb[l] = b_in[l*8 +: 8];
                pa[l] = cap_a[l];
                pb[l] = cap_b[l];
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [15:0] ea_out, ea_oe, eb_out, eb_oe;
        for (int l = 0; l < 2; l++) begin
            logic en;
            en = !oe_n[l];
            ea_oe[l*8 +: 8] = {8{en & !dir[l]}};
            eb_oe[l*8 +: 8] = {8{en &  dir[l]}};
            eb_out[l*8 +: 8] = (en && dir[l])  ? (sel_ab[l] ? ma[l] : a_in[l*8 +: 8]) : 8'h00;
            ea_out[l*8 +: 8] = (en && !dir[l]) ? (sel_ba[l] ? mb[l] : b_in[l*8 +: 8]) : 8'h00;
        end
        chk({tag, " a_oe R2/R3"}, a_oe, ea_oe);
        chk({tag, " b_oe R2/R3"}, b_oe, eb_oe);
        chk({tag, " b_out R4"}, b_out, eb_out);
        chk({tag, " a_out R5"}, a_out, ea_out);
    endtask

    // Check current inputs before the edge, then advance one clock.
    task automatic tick(input string tag);
        #1 compare_all(tag);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; oe_n = 2'b11; dir = 2'b00; sel_ab = 2'b00; sel_ba = 2'b00;
        cap_a = 2'b00; cap_b = 2'b00; a_in = 16'hFFFF; b_in = 16'hFFFF;
        @(negedge clk);
        tick("R2 reset");
        tick("R2 reset");
        rst = 1'b0;
        // R9: registers read zero on stored paths after reset
        oe_n = 2'b00; dir = 2'b01; sel_ab = 2'b11; sel_ba = 2'b11;
        #1;
        chk("R9 lane0 stored A", b_out[7:0], 8'h00);
        chk("R9 lane1 stored B", a_out[15:8], 8'h00);
        tick("R9");

        // R7: capture while both lanes isolated
        oe_n = 2'b11; a_in = 16'h3C5A; b_in = 16'h9612; cap_a = 2'b11;
        tick("R7 isolated");
        cap_a = 2'b00; a_in = 16'h0000;
        tick("R7");
        oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11;
        #1 chk("R7 stored after isolation", b_out, 16'h3C5A);
        tick("R7");

        // R8: both registers load at one edge
        oe_n = 2'b11; a_in = 16'hA1B2; b_in = 16'hC3D4; cap_a = 2'b11; cap_b = 2'b11;
        tick("R8");
        cap_a = 2'b00; cap_b = 2'b00; a_in = 16'h1111; b_in = 16'h2222;
        oe_n = 2'b00; dir = 2'b01; sel_ab = 2'b11; sel_ba = 2'b11;
        #1 chk("R8 lane0 A reg", b_out[7:0], 8'hB2);
        chk("R8 lane1 B reg", a_out[15:8], 8'hC3);
        tick("R8");

        // R6: strobe held high does not reload
        cap_a = 2'b01; a_in = 16'h0077;
        tick("R6");
        a_in = 16'h0099;
        tick("R6 held strobe");
        #1 chk("R6 no reload on held strobe", b_out[7:0], 8'h77);
        cap_a = 2'b00;
        tick("R6");

        // R10: capture while stored value is driven
        oe_n = 2'b00; dir = 2'b01; sel_ab = 2'b01; a_in = 16'h00E4; cap_a = 2'b01;
        #1 chk("R10 before edge", b_out[7:0], 8'h77);
        tick("R10");
        #1 chk("R10 after edge", b_out[7:0], 8'hE4);
        cap_a = 2'b00;
        tick("R10");

        // R1: lanes configured opposite, lane1 strobes leave lane0 alone
        oe_n = 2'b00; dir = 2'b01; sel_ab = 2'b00; sel_ba = 2'b00;
        a_in = 16'h5A6B; b_in = 16'h7C8D; cap_b = 2'b10;
        #1 chk("R1 lane0 live A on B", b_out, 16'h006B);
        chk("R1 lane1 live B on A", a_out, 16'h7C00);
        tick("R1");
        cap_b = 2'b00; sel_ab = 2'b01; sel_ba = 2'b10;
        #1 chk("R1 lane0 reg untouched", b_out[7:0], 8'hE4);
        chk("R1 lane1 reg loaded", a_out[15:8], 8'h7C);
        tick("R1");

        // Random run across every control combination
        for (int i = 0; i < 3000; i++) begin
            oe_n = 2'($urandom); dir = 2'($urandom);
            sel_ab = 2'($urandom); sel_ba = 2'($urandom);
            cap_a = 2'($urandom); cap_b = 2'($urandom);
            a_in = 16'($urandom); b_in = 16'($urandom);
            tick("R1/R6/R8/R10 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule